// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

A chain of 4-bit synchronous counter digits. Each digit counts either modulo 10 (BCD) or modulo 16 (binary), chosen by a parameter. A second parameter decides whether the active-low clear acts at once or only on a rising clock edge. Every digit can be preset from a parallel data input. Counting needs two enables, a parallel one and a trickle one.

Each digit drives a terminal-count signal. It is high when the digit sits at its maximum value and the digit's trickle enable is high. Inside the block that signal feeds the trickle enable of the next digit. All digits share the clock, the load control and the parallel enable, so a chain of any length advances on one edge with no ripple. The last digit's terminal count leaves the block, and a wider counter can be built by feeding it into the trickle enable of another instance.

Top module: `sync_cnt_chain`

## Requirements
- R1: With DECADE=1 a digit counts 0,1,...,9 and goes from 9 back to 0 on the next counting edge.
- R2: With DECADE=0 a digit counts 0,1,...,15 and goes from 15 back to 0 on the next counting edge.
- R3: With SYNC_CLR=0, a low rst_ni forces every digit to 0 at once, with no clock edge, and overrides all other inputs.
- R4: With SYNC_CLR=1, a low rst_ni does not change the count between edges. It clears every digit to 0 at the next rising edge, even if a load is requested at that edge.
- R5: When load_ni is low at a rising edge (and clear is inactive), count_o takes the value of data_i, whatever the state of either count enable. data_i[3:0] goes to the least significant digit.
- R6: When load_ni is high and cnt_en_p_i or cnt_en_t_i is low, the count holds at the rising edge.
- R7: tc_o is high exactly when cnt_en_t_i is high and every digit is at its maximum (9 when DECADE=1, 15 when DECADE=0). It does not depend on cnt_en_p_i.
- R8: With DECADE=1, a loaded value from 10 to 14 increments by one per counting edge, and 15 goes to 0, so the digit never locks up.
- R9: Digit k+1 counts only on edges where digit k and all lower digits are at maximum with both enables high. A chain therefore counts in plain decimal (DECADE=1) or plain binary (DECADE=0) sequence and wraps from all-maximum to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low clear; asynchronous or synchronous per SYNC_CLR |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | 4*NUM_STAGES | Preset value, lowest digit in bits 3:0 |
| cnt_en_p_i | input | 1 | Parallel count enable, shared by all digits |
| cnt_en_t_i | input | 1 | Trickle count enable of the lowest digit |
| count_o | output | 4*NUM_STAGES | Current count, lowest digit in bits 3:0 |
| tc_o | output | 1 | Terminal count of the highest digit |

## Verification
Four single-digit instances, one for each modulus and clear style, receive the same stimulus table. That table mixes loads, counts and holds with each enable low in turn. It tells the two moduli apart at the 9 and 15 boundaries and at out-of-range loaded values. It also shows that a load overrides low enables and that terminal count follows the trickle enable but not the parallel one. A directed clear, applied between edges while a load is requested, separates the immediate clear from the edge-timed clear. A three-digit decade chain and a two-digit binary chain then run through a full wrap, one check per edge. This confirms carry timing and terminal count, and that a low trickle enable freezes the whole chain.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned DIGIT_W = 4;

  function automatic logic [DIGIT_W-1:0] digit_max(input bit decade);
    return decade ? DIGIT_W'(9) : {DIGIT_W{1'b1}};
  endfunction
endpackage

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic [DIGIT_W-1:0] cur_i,
  input  logic [DIGIT_W-1:0] data_i,
  input  logic               load_ni,
  input  logic               cnt_en_i,
  output logic [DIGIT_W-1:0] nxt_o
);
  localparam logic [DIGIT_W-1:0] MAX_V = digit_max(DECADE);

  logic [DIGIT_W-1:0] inc;

  // out-of-range decade values fall through to plain increment, 15 wraps to 0
  always_comb begin
    if (DECADE && cur_i == MAX_V) inc = '0;
    else                          inc = cur_i + DIGIT_W'(1);
  end

  always_comb begin
    if (!load_ni)      nxt_o = data_i;
    else if (cnt_en_i) nxt_o = inc;
    else               nxt_o = cur_i;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter bit DECADE   = 1'b1,
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic [DIGIT_W-1:0] data_i,
  input  logic               cnt_en_p_i,
  input  logic               cnt_en_t_i,
  output logic [DIGIT_W-1:0] count_o,
  output logic               tc_o
);
  localparam logic [DIGIT_W-1:0] MAX_V = digit_max(DECADE);

  logic [DIGIT_W-1:0] cnt_q, cnt_d;

  cnt_next #(.DECADE(DECADE)) u_next (
    .cur_i    (cnt_q),
    .data_i   (data_i),
    .load_ni  (load_ni),
    .cnt_en_i (cnt_en_p_i & cnt_en_t_i),
    .nxt_o    (cnt_d)
  );

  generate
    if (SYNC_CLR) begin : g_sync_clr
      always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end
    end
  endgenerate

  assign count_o = cnt_q;
  assign tc_o    = cnt_en_t_i & (cnt_q == MAX_V);
endmodule

// File: rtl/sync_cnt_chain.sv
module sync_cnt_chain
  import cnt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 1,
  parameter bit          DECADE     = 1'b1,
  parameter bit          SYNC_CLR   = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_ni,
  input  logic [NUM_STAGES*DIGIT_W-1:0] data_i,
  input  logic                          cnt_en_p_i,
  input  logic                          cnt_en_t_i,
  output logic [NUM_STAGES*DIGIT_W-1:0] count_o,
  output logic                          tc_o
);
  // trickle enable of digit k; entry NUM_STAGES is the chain's terminal count
  logic [NUM_STAGES:0] trk;

  assign trk[0] = cnt_en_t_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_digit
    cnt_stage #(
      .DECADE   (DECADE),
      .SYNC_CLR (SYNC_CLR)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_ni    (load_ni),
      .data_i     (data_i[k*DIGIT_W +: DIGIT_W]),
      .cnt_en_p_i (cnt_en_p_i),
      .cnt_en_t_i (trk[k]),
      .count_o    (count_o[k*DIGIT_W +: DIGIT_W]),
      .tc_o       (trk[k+1])
    );
  end

  assign tc_o = trk[NUM_STAGES];
endmodule

// File: rtl/sync_cnt_chain_chk.sv
module sync_cnt_chain_chk
  import cnt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 1,
  parameter bit          DECADE     = 1'b1,
  parameter bit          SYNC_CLR   = 1'b0
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          load_ni,
  input logic [NUM_STAGES*DIGIT_W-1:0] data_i,
  input logic                          cnt_en_p_i,
  input logic                          cnt_en_t_i,
  input logic [NUM_STAGES*DIGIT_W-1:0] count_o,
  input logic                          tc_o
);
  localparam logic [DIGIT_W-1:0]            MAX_V   = digit_max(DECADE);
  localparam logic [NUM_STAGES*DIGIT_W-1:0] ALL_MAX = {NUM_STAGES{MAX_V}};

  logic past_valid = 1'b0;
  always_ff @(posedge clk_i) past_valid <= 1'b1;

  logic [DIGIT_W-1:0] low;
  logic               counting;
  assign low      = count_o[DIGIT_W-1:0];
  assign counting = load_ni & cnt_en_p_i & cnt_en_t_i;

  // R1 R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting && low == MAX_V |=> count_o[DIGIT_W-1:0] == '0);

  // R1 R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting && low < MAX_V |=> count_o[DIGIT_W-1:0] == $past(low) + DIGIT_W'(1));

  // R8
  oor_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting && low == 4'hF |=> count_o[DIGIT_W-1:0] == '0);

  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni && !(cnt_en_p_i && cnt_en_t_i) |=> $stable(count_o));

  // R7
  tc_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && tc_o |-> cnt_en_t_i && count_o == ALL_MAX);

  // R7
  tc_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && cnt_en_t_i && count_o == ALL_MAX |-> tc_o);

  // R4
  clr_edge_chk: assert property (@(posedge clk_i)
    past_valid && $past(!rst_ni) |-> count_o == '0);

  generate
    if (!SYNC_CLR) begin : g_async
      // R3
      clr_now_chk: assert property (@(posedge clk_i)
        past_valid && !rst_ni |-> count_o == '0);
    end
  endgenerate
endmodule

bind sync_cnt_chain sync_cnt_chain_chk #(
  .NUM_STAGES (NUM_STAGES),
  .DECADE     (DECADE),
  .SYNC_CLR   (SYNC_CLR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .cnt_en_p_i (cnt_en_p_i),
  .cnt_en_t_i (cnt_en_t_i),
  .count_o    (count_o),
  .tc_o       (tc_o)
);

// File: tb/tb_sync_cnt_chain.sv
module tb_sync_cnt_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1;
  logic [3:0] d = '0;
  logic cep = 1'b0, cet = 1'b0;
  logic ch_load_n = 1'b1, ch_cep = 1'b0, ch_cet = 1'b0;

  logic [3:0] q_da, q_ba, q_ds, q_bs;
  logic tc_da, tc_ba, tc_ds, tc_bs;
  logic [11:0] q_cd;
  logic [7:0]  q_cb;
  logic tc_cd, tc_cb;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sync_cnt_chain #(.NUM_STAGES(1), .DECADE(1'b1), .SYNC_CLR(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(d),
    .cnt_en_p_i(cep), .cnt_en_t_i(cet), .count_o(q_da), .tc_o(tc_da));
  sync_cnt_chain #(.NUM_STAGES(1), .DECADE(1'b0), .SYNC_CLR(1'b0)) dut_ba (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(d),
    .cnt_en_p_i(cep), .cnt_en_t_i(cet), .count_o(q_ba), .tc_o(tc_ba));
  sync_cnt_chain #(.NUM_STAGES(1), .DECADE(1'b1), .SYNC_CLR(1'b1)) dut_ds (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(d),
    .cnt_en_p_i(cep), .cnt_en_t_i(cet), .count_o(q_ds), .tc_o(tc_ds));
  sync_cnt_chain #(.NUM_STAGES(1), .DECADE(1'b0), .SYNC_CLR(1'b1)) dut_bs (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(d),
    .cnt_en_p_i(cep), .cnt_en_t_i(cet), .count_o(q_bs), .tc_o(tc_bs));
  sync_cnt_chain #(.NUM_STAGES(3), .DECADE(1'b1), .SYNC_CLR(1'b0)) dut_cd (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(ch_load_n), .data_i(12'h0),
    .cnt_en_p_i(ch_cep), .cnt_en_t_i(ch_cet), .count_o(q_cd), .tc_o(tc_cd));
  sync_cnt_chain #(.NUM_STAGES(2), .DECADE(1'b0), .SYNC_CLR(1'b1)) dut_cb (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(ch_load_n), .data_i(8'h0),
    .cnt_en_p_i(ch_cep), .cnt_en_t_i(ch_cet), .count_o(q_cb), .tc_o(tc_cb));

  // {load_n, d, cep, cet, exp_dec, exp_bin, tc_dec, tc_bin}
  localparam int NV = 14;
  localparam logic [16:0] VECS [NV] = '{
    {1'b0, 4'd7,  1'b1, 1'b1, 4'd7,  4'd7,  1'b0, 1'b0}, // R5 load with enables high
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  4'd8,  1'b0, 1'b0}, // R1 R2 count
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R7 decade max
    {1'b1, 4'd0,  1'b1, 1'b0, 4'd9,  4'd9,  1'b0, 1'b0}, // R6 trickle low holds, R7 tc gated
    {1'b1, 4'd0,  1'b0, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R6 parallel low holds, R7 cep ignored
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd10, 1'b0, 1'b0}, // R1 9->0, R2 9->10
    {1'b0, 4'd14, 1'b0, 1'b0, 4'd14, 4'd14, 1'b0, 1'b0}, // R5 load with enables low
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 4'd15, 1'b0, 1'b1}, // R8 14->15, R7 binary max
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 1'b0}, // R8 R2 15->0
    {1'b0, 4'd15, 1'b1, 1'b1, 4'd15, 4'd15, 1'b0, 1'b1}, // R5 load beats count
    {1'b0, 4'd9,  1'b1, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R5
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd10, 1'b0, 1'b0}, // R1 R2
    {1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0, 1'b0}, // R5 out-of-range load
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd13, 4'd13, 1'b0, 1'b0}  // R8 12->13
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [11:0] to_bcd(input int n);
    return {4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [11:0] hold_cd;
    logic [7:0]  hold_cb;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 reset da", 12'(q_da), 12'h0);
    check("R4 reset ds", 12'(q_ds), 12'h0);
    check("R3 reset chain", q_cd, 12'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {load_n, d, cep, cet} = VECS[i][16:10];
      edge_step();
      check($sformatf("R1 R5 R6 R8 vec%0d dec async", i), 12'(q_da), 12'(VECS[i][5:2] == 4'd0 && 1'b0 ? 4'd0 : VECS[i][9:6]));
      check($sformatf("R1 R5 R6 R8 vec%0d dec sync", i), 12'(q_ds), 12'(VECS[i][9:6]));
      check($sformatf("R2 R5 R6 vec%0d bin async", i), 12'(q_ba), 12'(VECS[i][5:2]));
      check($sformatf("R2 R5 R6 vec%0d bin sync", i), 12'(q_bs), 12'(VECS[i][5:2]));
      check($sformatf("R7 vec%0d tc dec", i), 12'({tc_da, tc_ds}), 12'({2{VECS[i][1]}}));
      check($sformatf("R7 vec%0d tc bin", i), 12'({tc_ba, tc_bs}), 12'({2{VECS[i][0]}}));
    end

    // clear between edges with a load requested: count is 13 everywhere
    load_n = 1'b0; d = 4'd5; cep = 1'b1; cet = 1'b1;
    #1;
    rst_n = 1'b0;
    #1;
    check("R3 async clear dec", 12'(q_da), 12'h0);
    check("R3 async clear bin", 12'(q_ba), 12'h0);
    check("R4 sync clear waits dec", 12'(q_ds), 12'd13);
    check("R4 sync clear waits bin", 12'(q_bs), 12'd13);
    edge_step();
    check("R4 sync clear beats load dec", 12'(q_ds), 12'h0);
    check("R4 sync clear beats load bin", 12'(q_bs), 12'h0);
    check("R3 async clear beats load", 12'(q_da), 12'h0);
    check("R3 chain cleared", q_cd, 12'h0);
    check("R4 chain cleared", 12'(q_cb), 12'h0);
    load_n = 1'b1;
    rst_n = 1'b1;

    // cascade run through a full wrap of both chains
    ch_cep = 1'b1; ch_cet = 1'b1;
    for (int n = 1; n <= 1100; n++) begin
      edge_step();
      check($sformatf("R9 dec chain n=%0d", n), q_cd, to_bcd(n % 1000));
      check($sformatf("R9 R7 dec chain tc n=%0d", n), 12'(tc_cd), 12'(n % 1000 == 999));
      check($sformatf("R9 bin chain n=%0d", n), 12'(q_cb), 12'(n % 256));
      check($sformatf("R9 R7 bin chain tc n=%0d", n), 12'(tc_cb), 12'(n % 256 == 255));
    end

    // trickle low freezes the chain
    hold_cd = q_cd;
    hold_cb = q_cb;
    ch_cet = 1'b0;
    repeat (3) edge_step();
    check("R6 R9 dec chain hold", q_cd, hold_cd);
    check("R6 R9 bin chain hold", 12'(q_cb), 12'(hold_cb));
    check("R7 chain tc low", 12'({tc_cd, tc_cb}), 12'h0);

    finish_run();
  end
endmodule